// File: doc/BRIEF.md
# Warp Register Stash Controller

This block shares a fixed pool of physical registers among the warps of one streaming multiprocessor. Registers are counted in chunks. A warp is not given a fixed allotment when it launches. Instead, each time it wants to issue an instruction it asks for the number of chunks that instruction's live registers need, and the controller answers in the same cycle. On a grant the warp's holding is set to exactly that count: a larger holding is topped up from the free pool, and a smaller one returns its surplus.

When a request cannot be met, the controller picks a victim warp and copies its chunks out, one per valid/ready handshake, on a single transfer port. The victim's chunks return to the pool only after the last one has been written. Suspended warps are brought back by reserving their chunks and reading them in again. They regain RUNNING only after the final read. A dispatched warp that has not started is launched only when no warp is suspended, so resumption always comes before new work.

The controller also keeps the state for one block-wide barrier. It releases the barrier only when every dispatched warp that has not retired has arrived. Warps that are suspended, spilling, filling or not yet started therefore hold the barrier closed.

Top module: `wrs_ctrl`

## Requirements
- R1: After reset every warp is IDLE (state code 0), the free count equals POOL_CHUNKS, mem_valid is low and bar_release is low.
- R2: A REQ command (op 1) is granted in the same cycle only when the target warp is RUNNING (code 1), is not waiting at the barrier, and needs no more chunks than its holding plus the free count. From the next cycle the warp holds exactly the requested count, and any surplus is back in the free count.
- R3: A REQ that is refused for lack of chunks, arriving while the transfer port is idle, turns a victim to SPILLING (code 2) in the next cycle. The victim is the RUNNING warp, other than the requester and not at the barrier, with the largest non-zero holding. On a tie the lowest warp index wins.
- R4: A spilling warp drives one write transfer (mem_write high) per held chunk, with chunk indices counting up from 0. Each index holds until its handshake. The chunks are returned to the free count, and the warp becomes SUSPENDED (code 3), only in the cycle after the last handshake.
- R5: While the port is idle and no REQ is presented, the lowest-index SUSPENDED warp whose stash fits in the free count becomes FILLING (code 4). Its stash is taken from the free count at that step.
- R6: A filling warp drives one read transfer (mem_write low) per stashed chunk, indices counting up from 0. It becomes RUNNING and holds its stash only after the last handshake.
- R7: A dispatched IDLE warp (dispatch is op 0) becomes RUNNING with no chunks held. This happens one warp per cycle, lowest index first, only while no warp is SUSPENDED and the free count is at least 1.
- R8: A RETIRE command (op 3) to a RUNNING warp that is not at the barrier makes it DONE (code 5) and returns its chunks to the free count in the next cycle.
- R9: bar_release is high exactly when at least one dispatched warp has not retired and every such warp has arrived at the barrier. Arrival is BARRIER (op 2) from a RUNNING warp. All arrivals clear at the clock edge where bar_release is high.
- R10: The following commands leave every state and the free count unchanged: REQ, RETIRE and BARRIER sent to a warp that is not RUNNING or is at the barrier, and DISPATCH sent to a warp that is not IDLE.
- R11: At all times the free count plus the chunks held by RUNNING and SPILLING warps plus the chunks reserved by FILLING warps equals POOL_CHUNKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 dispatch, 1 request, 2 barrier arrival, 3 retire |
| cmd_warp | input | $clog2(NUM_WARPS) | Warp addressed by the command |
| cmd_chunks | input | $clog2(MAX_NEED+1) | Live chunk count for a request |
| cmd_grant | output | 1 | Request granted (combinational) |
| bar_release | output | 1 | Barrier opens this cycle |
| mem_valid | output | 1 | Transfer chunk offered |
| mem_ready | input | 1 | Memory accepts the chunk |
| mem_write | output | 1 | 1 spill (write out), 0 fill (read back) |
| mem_warp | output | $clog2(NUM_WARPS) | Warp owning the chunk |
| mem_chunk | output | $clog2(POOL_CHUNKS+1) | Chunk index within the warp |
| warp_state | output | 3*NUM_WARPS | Per-warp state codes, warp i at bits 3i+2:3i |
| free_chunks | output | $clog2(POOL_CHUNKS+1) | Chunks in the free pool |

## Verification
The bench targets several corner cases, each of which would show up as a clear fault.

- Victim ties and barrier waiters. A wrong rule would spill the requester, spill a barrier waiter, or spill the higher-index warp on a tie.
- Freeing chunks during a stalled spill. If chunks returned before the last write, the free count would rise early, and the chunk-conservation sum would catch it.
- Launching beside a suspended warp whose stash does not fit. A design with the wrong priority would launch the new warp and starve the suspended one.
- A barrier held open by a suspended warp. Counting only running warps would release it early.

Random request streams with random stalls on the transfer port are checked every cycle against a model of the holdings, and shrinking requests are among them.

// File: rtl/wrs_pkg.sv
// Shared encodings for the warp register stash controller.
// Assumes state and command codes are fixed; widths do not depend on parameters.
package wrs_pkg;
    typedef enum logic [2:0] {
        WS_IDLE  = 3'd0,
        WS_RUN   = 3'd1,
        WS_SPILL = 3'd2,
        WS_SUSP  = 3'd3,
        WS_FILL  = 3'd4,
        WS_DONE  = 3'd5
    } wstate_e;

    typedef enum logic [1:0] {
        OP_DISPATCH = 2'd0,
        OP_REQ      = 2'd1,
        OP_BARRIER  = 2'd2,
        OP_RETIRE   = 2'd3
    } cmd_op_e;
endpackage

// File: rtl/wrs_first.sv
// Lowest-index picker: reports whether any mask bit is set and which is lowest.
// Assumes N >= 2; purely combinational.
module wrs_first #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  mask,
    output logic          valid,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wrs_victim.sv
// Victim selector: among candidate warps, picks the one holding the most
// chunks, lowest index on ties. Combinational; clk/rst_n only time its checks.
module wrs_victim #(
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int CW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][CW-1:0] held,
    output logic                 valid,
    output logic [IW-1:0]        idx
);
    logic [CW-1:0] best;

    // Strictly-greater compare keeps the earliest (lowest) index on ties.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!valid || held[i] > best)) begin
                valid = 1'b1;
                idx   = IW'(i);
                best  = held[i];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R3: no candidate holds more than the chosen victim
        a_r3_victim_largest: assert property (@(posedge clk) disable iff (!rst_n)
            valid && cand[g] |-> held[g] <= held[idx]);
        // R3: on equal holdings the chosen victim has the lower index
        a_r3_victim_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
            valid && cand[g] && held[g] == held[idx] |-> IW'(g) >= idx);
    end
endmodule

// File: rtl/wrs_xfer.sv
// Chunk transfer engine: moves cnt chunks of one warp over a valid/ready port,
// one per handshake, indices from 0 upward, and pulses fin on the last one.
// Assumes start only while idle and cnt > 0.
module wrs_xfer #(
    parameter int IW = 2,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] start_warp,
    input  logic          start_write,
    input  logic [CW-1:0] start_cnt,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [IW-1:0] mem_warp,
    output logic [CW-1:0] mem_chunk,
    output logic          fin
);
    logic          busy_q;
    logic [IW-1:0] warp_q;
    logic          wr_q;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] tot_q;

    assign mem_valid = busy_q;
    assign mem_write = wr_q;
    assign mem_warp  = warp_q;
    assign mem_chunk = idx_q;
    assign fin       = busy_q && mem_ready && (idx_q == tot_q - 1'b1);

    // Load a new job, or step the chunk index on each accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            warp_q <= '0;
            wr_q   <= 1'b0;
            idx_q  <= '0;
            tot_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            warp_q <= start_warp;
            wr_q   <= start_write;
            idx_q  <= '0;
            tot_q  <= start_cnt;
        end else if (busy_q && mem_ready) begin
            if (fin) busy_q <= 1'b0;
            else     idx_q  <= idx_q + 1'b1;
        end
    end

    // R4: a job never starts on top of one in flight, and never empty
    a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q && start_cnt != '0);
    // R4: an offered chunk holds still until it is accepted
    a_r4_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_chunk) && $stable(mem_warp));
endmodule

// File: rtl/wrs_ctrl.sv
// Warp register stash controller top. Grants live-register chunks per request,
// spills a victim when the pool is short, refills suspended warps before
// launching new ones, and tracks one block-wide barrier.
// Assumes at most one command per cycle and requests no larger than MAX_NEED.
module wrs_ctrl
    import wrs_pkg::*;
#(
    parameter int NUM_WARPS   = 4,
    parameter int POOL_CHUNKS = 8,
    parameter int MAX_NEED    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_valid,
    input  logic [1:0]                        cmd_op,
    input  logic [$clog2(NUM_WARPS)-1:0]      cmd_warp,
    input  logic [$clog2(MAX_NEED+1)-1:0]     cmd_chunks,
    output logic                              cmd_grant,
    output logic                              bar_release,
    output logic                              mem_valid,
    input  logic                              mem_ready,
    output logic                              mem_write,
    output logic [$clog2(NUM_WARPS)-1:0]      mem_warp,
    output logic [$clog2(POOL_CHUNKS+1)-1:0]  mem_chunk,
    output logic [3*NUM_WARPS-1:0]            warp_state,
    output logic [$clog2(POOL_CHUNKS+1)-1:0]  free_chunks
);
    localparam int WW = $clog2(NUM_WARPS);
    localparam int CW = $clog2(POOL_CHUNKS + 1);
    localparam int NW = $clog2(MAX_NEED + 1);
    localparam int XW = ((CW > NW) ? CW : NW) + 2;

    wstate_e                      st_q [NUM_WARPS];
    logic [NUM_WARPS-1:0][CW-1:0] held_q;
    logic [NUM_WARPS-1:0][CW-1:0] stash_q;
    logic [NUM_WARPS-1:0]         bar_q, disp_q;
    logic [CW-1:0]                free_q;
    logic [XW-1:0]                free_n;

    logic [NUM_WARPS-1:0] vic_cand, res_cand, lau_cand, susp_m, done_m;
    logic                 vic_ok, res_ok, lau_ok;
    logic [WW-1:0]        vic_idx, res_idx, lau_idx;
    logic                 x_busy, x_fin, x_start;

    // Command decode against the addressed warp.
    logic          is_req, w_ok, fits, spill_go, res_go, lau_go;
    logic          retire_go, bar_go, disp_go;
    logic [XW-1:0] need_x, held_x, free_x;

    assign is_req    = cmd_valid && cmd_op == OP_REQ;
    assign w_ok      = st_q[cmd_warp] == WS_RUN && !bar_q[cmd_warp];
    assign need_x    = XW'(cmd_chunks);
    assign held_x    = XW'(held_q[cmd_warp]);
    assign free_x    = XW'(free_q);
    assign fits      = need_x <= held_x + free_x;
    assign cmd_grant = is_req && w_ok && fits;
    assign retire_go = cmd_valid && cmd_op == OP_RETIRE && w_ok;
    assign bar_go    = cmd_valid && cmd_op == OP_BARRIER && w_ok;
    assign disp_go   = cmd_valid && cmd_op == OP_DISPATCH && st_q[cmd_warp] == WS_IDLE;

    // Per-warp candidate masks for victim, resume and launch selection.
    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_mask
        assign vic_cand[g] = st_q[g] == WS_RUN && !bar_q[g] && held_q[g] != '0
                             && cmd_warp != WW'(g);
        assign susp_m[g]   = st_q[g] == WS_SUSP;
        assign res_cand[g] = susp_m[g] && stash_q[g] <= free_q;
        assign lau_cand[g] = st_q[g] == WS_IDLE && disp_q[g];
        assign done_m[g]   = st_q[g] == WS_DONE;
        assign warp_state[3*g +: 3] = st_q[g];
    end

    wrs_victim #(.N(NUM_WARPS), .IW(WW), .CW(CW)) u_vic (
        .clk(clk), .rst_n(rst_n), .cand(vic_cand), .held(held_q),
        .valid(vic_ok), .idx(vic_idx));
    wrs_first #(.N(NUM_WARPS), .IW(WW)) u_res (
        .mask(res_cand), .valid(res_ok), .idx(res_idx));
    wrs_first #(.N(NUM_WARPS), .IW(WW)) u_lau (
        .mask(lau_cand), .valid(lau_ok), .idx(lau_idx));

    assign x_busy   = mem_valid;
    assign spill_go = is_req && w_ok && !fits && !x_busy && vic_ok;
    assign res_go   = !x_busy && !is_req && res_ok;
    assign lau_go   = lau_ok && susp_m == '0 && free_q != '0;
    assign x_start  = spill_go || res_go;

    wrs_xfer #(.IW(WW), .CW(CW)) u_xfer (
        .clk(clk), .rst_n(rst_n), .start(x_start),
        .start_warp(spill_go ? vic_idx : res_idx),
        .start_write(spill_go),
        .start_cnt(spill_go ? held_q[vic_idx] : stash_q[res_idx]),
        .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_warp(mem_warp), .mem_chunk(mem_chunk), .fin(x_fin));

    // Barrier opens when every live dispatched warp has arrived.
    logic [NUM_WARPS-1:0] part;
    assign part        = disp_q & ~done_m;
    assign bar_release = part != '0 && (bar_q & part) == part;
    assign free_chunks = free_q;

    // Next free count: grant delta, retire and spill returns, refill reservation.
    always_comb begin
        free_n = free_x;
        if (cmd_grant) free_n = free_x + held_x - need_x;
        if (retire_go) free_n = free_n + held_x;
        if (x_fin && mem_write) free_n = free_n + XW'(held_q[mem_warp]);
        if (res_go) free_n = free_n - XW'(stash_q[res_idx]);
    end

    // Per-warp state, holding, stash and barrier bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WARPS; i++) st_q[i] <= WS_IDLE;
            held_q  <= '0;
            stash_q <= '0;
            bar_q   <= '0;
            disp_q  <= '0;
            free_q  <= CW'(POOL_CHUNKS);
        end else begin
            free_q <= free_n[CW-1:0];
            if (bar_release) bar_q <= '0;
            for (int i = 0; i < NUM_WARPS; i++) begin
                if (cmd_grant && cmd_warp == WW'(i)) held_q[i] <= CW'(cmd_chunks);
                if (retire_go && cmd_warp == WW'(i)) begin
                    st_q[i]   <= WS_DONE;
                    held_q[i] <= '0;
                end
                if (bar_go && cmd_warp == WW'(i))  bar_q[i]  <= 1'b1;
                if (disp_go && cmd_warp == WW'(i)) disp_q[i] <= 1'b1;
                if (spill_go && vic_idx == WW'(i)) st_q[i] <= WS_SPILL;
                if (res_go && res_idx == WW'(i))   st_q[i] <= WS_FILL;
                if (lau_go && lau_idx == WW'(i))   st_q[i] <= WS_RUN;
                if (x_fin && mem_warp == WW'(i)) begin
                    if (mem_write) begin
                        st_q[i]    <= WS_SUSP;
                        stash_q[i] <= held_q[i];
                        held_q[i]  <= '0;
                    end else begin
                        st_q[i]   <= WS_RUN;
                        held_q[i] <= stash_q[i];
                    end
                end
            end
        end
    end

    // R11: the free count never exceeds the pool
    a_r11_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_q <= CW'(POOL_CHUNKS));
    // R2: a granted warp holds exactly the requested count next cycle
    a_r2_hold_need: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_grant |=> held_q[$past(cmd_warp)] == CW'($past(cmd_chunks)));
    // R3: the chosen victim is SPILLING in the next cycle
    a_r3_spill_state: assert property (@(posedge clk) disable iff (!rst_n)
        spill_go |=> st_q[$past(vic_idx)] == WS_SPILL);
    // R4: write transfers belong to a spilling warp
    a_r4_spill_owner: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> st_q[mem_warp] == WS_SPILL);
    // R6: read transfers belong to a filling warp
    a_r6_fill_owner: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_write |-> st_q[mem_warp] == WS_FILL);
    // R9: arrivals are cleared after a release
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bar_release |=> bar_q == '0);
endmodule

// File: tb/wrs_ctrl_tb.sv
`timescale 1ns/1ps
module wrs_ctrl_tb;
    localparam int NWARP = 4;
    localparam int POOL  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [1:0] cmd_warp = '0;
    logic [3:0] cmd_chunks = '0;
    logic       cmd_grant, bar_release, mem_valid, mem_write;
    logic       mem_ready = 1'b0;
    logic [1:0] mem_warp;
    logic [3:0] mem_chunk;
    logic [11:0] warp_state;
    logic [3:0] free_chunks;

    wrs_ctrl #(.NUM_WARPS(NWARP), .POOL_CHUNKS(POOL), .MAX_NEED(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_warp(cmd_warp), .cmd_chunks(cmd_chunks), .cmd_grant(cmd_grant),
        .bar_release(bar_release), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_warp(mem_warp), .mem_chunk(mem_chunk),
        .warp_state(warp_state), .free_chunks(free_chunks));

    always #2.5 clk = ~clk;

    localparam int S_IDLE = 0, S_RUN = 1, S_SPILL = 2, S_SUSP = 3, S_FILL = 4, S_DONE = 5;
    localparam int O_DISP = 0, O_REQ = 1, O_BAR = 2, O_RET = 3;

    int  nchk = 0, nfail = 0;
    bit  finished = 1'b0;
    int  mh [NWARP];
    int  ms [NWARP];
    bit  mbar [NWARP];
    bit  mdisp [NWARP];
    int  pst [NWARP];
    int  hs;

    function automatic int wst(int i);
        return int'(warp_state[3*i +: 3]);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0; cmd_valid = 1'b0; mem_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NWARP; i++) begin
            mh[i] = 0; ms[i] = 0; mbar[i] = 0; mdisp[i] = 0; pst[i] = S_IDLE;
        end
        hs = 0;
    endtask

    // One cycle: drive at negedge, check combinational answers, advance, update model.
    task automatic step(bit v, int op, int w, int n, bit rdy);
        int st, ev, best, gw, cnt, arr, sum;
        bit ok, egr, erel, pbar, pdisp, rel;
        cmd_valid = v; cmd_op = 2'(op); cmd_warp = 2'(w); cmd_chunks = 4'(n);
        mem_ready = rdy;
        #1;
        st  = wst(w);
        ok  = v && op == O_REQ && st == S_RUN && !mbar[w];
        egr = ok && (n <= mh[w] + int'(free_chunks));
        check(cmd_grant == egr, "R2 grant decision", int'(cmd_grant), int'(egr));
        cnt = 0; arr = 0;
        for (int i = 0; i < NWARP; i++)
            if (mdisp[i] && wst(i) != S_DONE) begin
                cnt++;
                if (mbar[i]) arr++;
            end
        erel = cnt > 0 && arr == cnt;
        check(bar_release == erel, "R9 barrier release", int'(bar_release), int'(erel));
        ev = -1; best = 0;
        if (ok && !egr && !mem_valid)
            for (int i = 0; i < NWARP; i++)
                if (i != w && wst(i) == S_RUN && !mbar[i] && mh[i] > best) begin
                    ev = i; best = mh[i];
                end
        if (mem_valid && mem_ready) begin
            check(int'(mem_chunk) == hs, "R4/R6 chunk order", int'(mem_chunk), hs);
            hs++;
        end
        gw    = egr ? w : -1;
        pbar  = v && op == O_BAR && st == S_RUN && !mbar[w];
        pdisp = v && op == O_DISP && st == S_IDLE;
        rel   = bar_release;
        @(negedge clk);
        if (gw >= 0) mh[gw] = n;
        if (rel) for (int i = 0; i < NWARP; i++) mbar[i] = 0;
        if (pbar) mbar[w] = 1;
        if (pdisp) mdisp[w] = 1;
        for (int i = 0; i < NWARP; i++) begin
            int ns;
            ns = wst(i);
            if (pst[i] == S_SPILL && ns == S_SUSP) begin
                check(hs == mh[i], "R4 spill chunk count", hs, mh[i]);
                ms[i] = mh[i]; mh[i] = 0;
            end
            if (pst[i] == S_FILL && ns == S_RUN) begin
                check(hs == ms[i], "R6 fill chunk count", hs, ms[i]);
                mh[i] = ms[i];
            end
            if (pst[i] == S_RUN && ns == S_DONE) mh[i] = 0;
            if (ns != pst[i] && (ns == S_SPILL || ns == S_FILL)) hs = 0;
            pst[i] = ns;
        end
        if (ev >= 0) check(wst(ev) == S_SPILL, "R3 victim choice", wst(ev), S_SPILL);
        sum = int'(free_chunks);
        for (int i = 0; i < NWARP; i++) begin
            if (pst[i] == S_RUN || pst[i] == S_SPILL) sum += mh[i];
            if (pst[i] == S_FILL) sum += ms[i];
        end
        check(sum == POOL, "R11 chunk conservation", sum, POOL);
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        reset_dut();
        // R1: reset state
        for (int i = 0; i < NWARP; i++) check(wst(i) == S_IDLE, "R1 reset state", wst(i), S_IDLE);
        check(int'(free_chunks) == POOL, "R1 reset free", int'(free_chunks), POOL);
        check(!mem_valid && !bar_release, "R1 reset outputs", int'(mem_valid), 0);

        // R7: launch lowest first, one per cycle
        step(1, O_DISP, 0, 0, 1);
        step(1, O_DISP, 1, 0, 1);
        check(wst(0) == S_RUN && wst(1) == S_IDLE, "R7 launch order", wst(1), S_IDLE);
        idle(1);
        check(wst(1) == S_RUN, "R7 second launch", wst(1), S_RUN);

        // R2: grants, including a shrink that returns surplus
        step(1, O_REQ, 0, 5, 1);
        check(int'(free_chunks) == 3, "R2 free after grow", int'(free_chunks), 3);
        step(1, O_REQ, 1, 3, 1);
        step(1, O_REQ, 1, 2, 1);
        check(int'(free_chunks) == 1, "R2 free after shrink", int'(free_chunks), 1);

        // R3/R4: refused request spills W0 under a stalling port
        step(1, O_REQ, 1, 4, 0);
        check(wst(0) == S_SPILL, "R3 victim W0", wst(0), S_SPILL);
        for (int k = 0; k < 40 && wst(0) == S_SPILL; k++) begin
            check(int'(free_chunks) == 1, "R4 no early return", int'(free_chunks), 1);
            step(1, O_REQ, 1, 4, k[0]);
        end
        check(wst(0) == S_SUSP, "R4 suspended", wst(0), S_SUSP);
        check(int'(free_chunks) == 6, "R4 chunks returned", int'(free_chunks), 6);
        step(1, O_REQ, 1, 4, 1);
        check(int'(free_chunks) == 4, "R2 grant after spill", int'(free_chunks), 4);

        // R5/R7: stash 5 does not fit 4; new warp must not launch meanwhile
        step(1, O_DISP, 2, 0, 1);
        idle(4);
        check(wst(0) == S_SUSP, "R5 no resume without room", wst(0), S_SUSP);
        check(wst(2) == S_IDLE, "R7 launch blocked by suspended", wst(2), S_IDLE);

        // R10: commands to a suspended warp are ignored
        step(1, O_RET, 0, 0, 1);
        step(1, O_REQ, 0, 1, 1);
        check(wst(0) == S_SUSP, "R10 suspended unchanged", wst(0), S_SUSP);
        check(int'(free_chunks) == 4, "R10 free unchanged", int'(free_chunks), 4);

        // R8: retire returns chunks; R5/R6: resume then refill
        step(1, O_RET, 1, 0, 1);
        check(wst(1) == S_DONE, "R8 retired", wst(1), S_DONE);
        check(int'(free_chunks) == 8, "R8 chunks returned", int'(free_chunks), 8);
        idle(1);
        check(wst(0) == S_FILL, "R5 resume", wst(0), S_FILL);
        check(int'(free_chunks) == 3, "R5 stash reserved", int'(free_chunks), 3);
        for (int k = 0; k < 40 && wst(0) == S_FILL; k++) step(0, 0, 0, 0, k[0]);
        check(wst(0) == S_RUN, "R6 refilled", wst(0), S_RUN);
        idle(2);
        check(wst(2) == S_RUN, "R7 launch after resume", wst(2), S_RUN);

        // R9: barrier over W0 and W2
        step(1, O_BAR, 0, 0, 1);
        check(!bar_release, "R9 partial arrival", int'(bar_release), 0);
        step(1, O_BAR, 2, 0, 1);
        check(bar_release, "R9 full arrival", int'(bar_release), 1);
        idle(1);
        step(1, O_RET, 1, 0, 1);
        check(wst(1) == S_DONE && int'(free_chunks) == 3, "R10 retire of done warp",
              int'(free_chunks), 3);

        // R9: a suspended warp holds the barrier closed
        step(1, O_REQ, 0, 8, 1);
        step(1, O_REQ, 2, 1, 1);
        for (int k = 0; k < 40 && wst(0) != S_SUSP; k++) step(1, O_REQ, 2, 1, 1);
        step(1, O_REQ, 2, 1, 1);
        step(1, O_BAR, 2, 0, 1);
        idle(3);
        check(!bar_release && wst(0) == S_SUSP, "R9 suspended blocks release",
              int'(bar_release), 0);

        // Random phase
        for (int round = 0; round < 10; round++) begin
            reset_dut();
            for (int i = 0; i < NWARP; i++) step(1, O_DISP, i, 0, 1);
            for (int k = 0; k < 400; k++) begin
                int r, op;
                r  = int'($urandom % 100);
                op = (r < 85) ? O_REQ : (r < 88) ? O_BAR : (r < 90) ? O_RET : O_DISP;
                step(r < 95, op, int'($urandom % NWARP), int'($urandom % 9),
                     ($urandom % 4) != 0);
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule